// File: doc/BRIEF.md
# Offline Flyback Supervisory Sequencer

This block is the digital supervisor of an offline flyback controller. It takes one-bit comparator flags, already synchronized to its clock. They report the supply rail against its turn-on, turn-off and latch-clear levels, plus supply overvoltage, feedback overload, die over-temperature, a current-sense spike that signals a shorted winding, and the high and low levels of the blanking pin. From these flags it decides when the startup current source charges the supply capacitor, when the internal reference runs and when the power switch may be gated. It also produces a stepped soft-start ramp code that the pulse-width stage uses as its peak-current ceiling.

After power-up the block waits in lockout until the supply crosses the turn-on level. It then runs a counter-paced soft start and settles into normal operation. A fault leads to one of two outcomes. Thermal, overvoltage, shorted-winding and external-latch faults freeze the converter in a latched-off state, and only a deep supply discharge clears it. A sustained overload is handled differently: it is first tolerated for a fixed basic blanking window. The block then switches on the current source that charges an external blanking capacitor, and only when that pin reaches its upper level does the converter drop into an auto-restart cycle.

All windows are given in milliseconds together with the clock rate in kHz, so a scaled clock shortens every window without touching the logic.

Top module: `flysup_top`

## Requirements
- R1: Out of reset and while in lockout, startup_en is 1 and ref_en, gate_en, blank_src_en and ramp_code are 0. In lockout, the flags for overtemperature, short winding, blanking-pin low, overvoltage and overload have no effect.
- R2: In lockout, vcc_above_on at a clock edge leads to soft start from the next cycle: gate_en and ref_en are 1 and startup_en is 0.
- R3: During soft start, ramp_code starts at 0 and rises by one every SS_STEP = CLK_KHZ*SS_MS/2^RAMP_W cycles. After SS_STEP*2^RAMP_W cycles the block enters normal operation, where ramp_code holds all ones.
- R4: In soft start or normal operation, vcc_below_off returns the block to lockout on the next cycle, with gate_en 0 and startup_en 1.
- R5: In soft start or normal operation, any of the following leads to the latched-off state: temp_over, cs_short, blank_pin_low, or vcc_over together with fb_over. vcc_over alone has no effect. In the latched-off state gate_en and ref_en are 0, and startup_en is 0 on entry.
- R6: When conditions coincide, latch faults win over undervoltage, and undervoltage wins over an overload trip.
- R7: In normal operation, after BLANK = CLK_KHZ*BLANK_MS consecutive cycles with fb_over high, blank_src_en goes to 1 while gate_en stays 1. Outside normal operation blank_src_en is 0.
- R8: A cycle with fb_over low clears the overload timer, so the full BLANK count is needed again and blank_src_en drops.
- R9: While blank_src_en is 1, fb_over together with blank_pin_high leads to auto-restart on the next cycle: gate_en 0, startup_en 0, ref_en 1. blank_pin_high has no effect before blank_src_en is 1. In auto-restart, vcc_below_off leads to lockout, and the next turn-on runs a full soft start again.
- R10: In the latched-off state startup_en becomes 1 after vcc_below_off and 0 after vcc_above_on, and holds its value otherwise.
- R11: The latched-off state is left only through vcc_below_reset, which leads to lockout. Turn-on and all fault flags leave it latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_above_on | input | 1 | Supply above turn-on level |
| vcc_below_off | input | 1 | Supply below turn-off level |
| vcc_below_reset | input | 1 | Supply below latch-clear level |
| vcc_over | input | 1 | Supply overvoltage |
| fb_over | input | 1 | Feedback above overload level |
| temp_over | input | 1 | Die over-temperature |
| cs_short | input | 1 | Current sense above short-winding level |
| blank_pin_high | input | 1 | Blanking pin above its upper level |
| blank_pin_low | input | 1 | Blanking pin pulled below its latch level |
| startup_en | output | 1 | Startup current source enable |
| ref_en | output | 1 | Internal reference enable |
| gate_en | output | 1 | Power switch gating allowed |
| ramp_code | output | RAMP_W | Soft-start ceiling code |
| blank_src_en | output | 1 | Blanking capacitor current source enable |

## Verification
The bench builds the block with CLK_KHZ=8 and RAMP_W=4, keeping both windows at 20 ms. This gives a soft start of 160 cycles paced at 10 cycles per code step, and a basic blanking window of 160 cycles. Each pass through soft start, each overload hold and each interrupted overload therefore fits in a few hundred cycles. Many start-fault-recover sequences can then run in one pass: every latch cause, coinciding faults, an overload dropped before its timeout, a full restart cycle and the latched supply hysteresis.

// File: rtl/flysup_pkg.sv
package flysup_pkg;
    typedef enum logic [2:0] {
        ST_LOCKOUT   = 3'd0,
        ST_SOFTSTART = 3'd1,
        ST_NORMAL    = 3'd2,
        ST_RESTART   = 3'd3,
        ST_LATCHED   = 3'd4
    } sup_state_e;

    typedef struct packed {
        sup_state_e state;
        logic       lsrc;
    } sup_regs_t;
endpackage

// File: rtl/flysup_ramp.sv
module flysup_ramp #(
    parameter int RAMP_W  = 6,
    parameter int SS_STEP = 312
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    output logic [RAMP_W-1:0] code,
    output logic              done
);
    localparam int STEP_W = (SS_STEP > 1) ? $clog2(SS_STEP) : 1;
    localparam logic [RAMP_W-1:0] CODE_MAX  = {RAMP_W{1'b1}};
    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(SS_STEP - 1);

    typedef struct packed {
        logic [RAMP_W-1:0] code;
        logic [STEP_W-1:0] step;
    } ramp_regs_t;

    ramp_regs_t r_d, r_q;

    always_comb begin
        r_d  = r_q;
        done = 1'b0;
        if (!run) begin
            r_d = '0;
        end else if (r_q.step == STEP_LAST) begin
            r_d.step = '0;
            if (r_q.code == CODE_MAX) done = 1'b1;
            else                      r_d.code = r_q.code + 1'b1;
        end else begin
            r_d.step = r_q.step + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign code = r_q.code;

    // R3: code only holds or climbs by one while the ramp keeps running
    a_r3_ramp_step: assert property (@(posedge clk) disable iff (!rst_n)
        run && $past(run) |-> (code == $past(code)) || (code == $past(code) + 1'b1));
endmodule

// File: rtl/flysup_blank.sv
module flysup_blank #(
    parameter int BLANK = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic fb_over,
    input  logic pin_high,
    output logic src_en,
    output logic trip
);
    localparam int CW = $clog2(BLANK + 1);
    localparam logic [CW-1:0] LIMIT = CW'(BLANK);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!arm || !fb_over)  cnt_d = '0;
        else if (cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign src_en = (cnt_q == LIMIT);
    assign trip   = src_en && fb_over && pin_high;

    // R8: a quiet feedback cycle always withdraws the extended window
    a_r8_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !fb_over |=> !src_en);
endmodule

// File: rtl/flysup_top.sv
module flysup_top
    import flysup_pkg::*;
#(
    parameter int CLK_KHZ  = 1000,
    parameter int SS_MS    = 20,
    parameter int BLANK_MS = 20,
    parameter int RAMP_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vcc_above_on,
    input  logic              vcc_below_off,
    input  logic              vcc_below_reset,
    input  logic              vcc_over,
    input  logic              fb_over,
    input  logic              temp_over,
    input  logic              cs_short,
    input  logic              blank_pin_high,
    input  logic              blank_pin_low,
    output logic              startup_en,
    output logic              ref_en,
    output logic              gate_en,
    output logic [RAMP_W-1:0] ramp_code,
    output logic              blank_src_en
);
    localparam int SS_CYC  = CLK_KHZ * SS_MS;
    localparam int SS_STEP = (SS_CYC >> RAMP_W) > 0 ? (SS_CYC >> RAMP_W) : 1;
    localparam int BLANK   = (CLK_KHZ * BLANK_MS) > 0 ? (CLK_KHZ * BLANK_MS) : 1;

    sup_regs_t         s_d, s_q;
    logic              ramp_run, ramp_done;
    logic [RAMP_W-1:0] ramp_cnt;
    logic              blk_arm, blk_src, blk_trip;
    logic              latch_fault, switching;

    assign switching   = (s_q.state == ST_SOFTSTART) || (s_q.state == ST_NORMAL);
    assign latch_fault = (vcc_over && fb_over) || temp_over || cs_short || blank_pin_low;
    assign ramp_run    = (s_q.state == ST_SOFTSTART);
    assign blk_arm     = (s_q.state == ST_NORMAL);

    flysup_ramp #(.RAMP_W(RAMP_W), .SS_STEP(SS_STEP)) i_ramp (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (ramp_run),
        .code (ramp_cnt),
        .done (ramp_done)
    );

    flysup_blank #(.BLANK(BLANK)) i_blank (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (blk_arm),
        .fb_over (fb_over),
        .pin_high(blank_pin_high),
        .src_en  (blk_src),
        .trip    (blk_trip)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.state)
            ST_LOCKOUT: begin
                if (vcc_above_on) s_d.state = ST_SOFTSTART;
            end
            ST_SOFTSTART, ST_NORMAL: begin
                if (latch_fault) begin
                    s_d.state = ST_LATCHED;
                    s_d.lsrc  = 1'b0;
                end else if (vcc_below_off) begin
                    s_d.state = ST_LOCKOUT;
                end else if (s_q.state == ST_NORMAL && blk_trip) begin
                    s_d.state = ST_RESTART;
                end else if (s_q.state == ST_SOFTSTART && ramp_done) begin
                    s_d.state = ST_NORMAL;
                end
            end
            ST_RESTART: begin
                if (vcc_below_off) s_d.state = ST_LOCKOUT;
            end
            ST_LATCHED: begin
                if (vcc_below_reset)    s_d.state = ST_LOCKOUT;
                else if (vcc_below_off) s_d.lsrc  = 1'b1;
                else if (vcc_above_on)  s_d.lsrc  = 1'b0;
            end
            default: s_d.state = ST_LOCKOUT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{state: ST_LOCKOUT, lsrc: 1'b0};
        else        s_q <= s_d;
    end

    assign startup_en   = (s_q.state == ST_LOCKOUT) || ((s_q.state == ST_LATCHED) && s_q.lsrc);
    assign ref_en       = switching || (s_q.state == ST_RESTART);
    assign gate_en      = switching;
    assign blank_src_en = blk_arm && blk_src;
    assign ramp_code    = (s_q.state == ST_NORMAL)    ? {RAMP_W{1'b1}} :
                          (s_q.state == ST_SOFTSTART) ? ramp_cnt : '0;

    // R4: undervoltage while switching falls back to lockout
    a_r4_uv_lockout: assert property (@(posedge clk) disable iff (!rst_n)
        switching && vcc_below_off && !latch_fault |=> !gate_en && startup_en);
    // R5: a latch cause while switching removes gate and reference
    a_r5_latch_entry: assert property (@(posedge clk) disable iff (!rst_n)
        gate_en && latch_fault |=> !gate_en && !ref_en && !startup_en);
    // R11: latched state persists until the deep discharge flag
    a_r11_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_LATCHED) && !vcc_below_reset |=> (s_q.state == ST_LATCHED) && !gate_en);
    // R10: startup source follows the off threshold while latched
    a_r10_latch_src: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_LATCHED) && vcc_below_off && !vcc_below_reset |=> startup_en);
    // R7: blanking source only ever runs while the switch is gated
    a_r7_blank_gate: assert property (@(posedge clk) disable iff (!rst_n)
        blank_src_en |-> gate_en);
endmodule

// File: tb/test_flysup_top.sv
module test_flysup_top;
    localparam int CLK_KHZ  = 8;
    localparam int SS_MS    = 20;
    localparam int BLANK_MS = 20;
    localparam int RAMP_W   = 4;
    localparam int SS_TOTAL = CLK_KHZ * SS_MS;
    localparam int STEP     = SS_TOTAL / (1 << RAMP_W);
    localparam int BLANKN   = CLK_KHZ * BLANK_MS;
    localparam int CMAX     = (1 << RAMP_W) - 1;

    localparam int M_LO = 0, M_SS = 1, M_NM = 2, M_RS = 3, M_LA = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic von = 0, uv = 0, rlow = 0, ovp = 0, fbo = 0, otp = 0, csh = 0, bhi = 0, blo = 0;
    logic startup_en, ref_en, gate_en, blank_src_en;
    logic [RAMP_W-1:0] ramp_code;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    string cur_req = "R1";

    int m_st = M_LO;
    int m_ss = 0;
    int m_bc = 0;
    bit m_ls = 0;

    flysup_top #(.CLK_KHZ(CLK_KHZ), .SS_MS(SS_MS), .BLANK_MS(BLANK_MS), .RAMP_W(RAMP_W)) i_flysup_top (
        .clk(clk), .rst_n(rst_n), .vcc_above_on(von), .vcc_below_off(uv),
        .vcc_below_reset(rlow), .vcc_over(ovp), .fb_over(fbo), .temp_over(otp),
        .cs_short(csh), .blank_pin_high(bhi), .blank_pin_low(blo),
        .startup_en(startup_en), .ref_en(ref_en), .gate_en(gate_en),
        .ramp_code(ramp_code), .blank_src_en(blank_src_en)
    );

    always #4 clk = ~clk;

    // behavioural reference of the sequencing rules
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = M_LO; m_ss = 0; m_bc = 0; m_ls = 0;
        end else begin
            bit lf;
            bit trip;
            lf   = (ovp && fbo) || otp || csh || blo;
            trip = (m_bc == BLANKN) && fbo && bhi;
            case (m_st)
                M_LO: if (von) begin m_st = M_SS; m_ss = 0; m_bc = 0; end
                M_SS, M_NM: begin
                    if (lf) begin m_st = M_LA; m_ls = 0; end
                    else if (uv) m_st = M_LO;
                    else if (m_st == M_NM && trip) m_st = M_RS;
                    else if (m_st == M_SS) begin
                        m_ss++;
                        m_bc = 0;
                        if (m_ss == SS_TOTAL) m_st = M_NM;
                    end else begin
                        if (!fbo) m_bc = 0;
                        else if (m_bc < BLANKN) m_bc++;
                    end
                    if (m_st != M_NM) m_bc = 0;
                end
                M_RS: if (uv) m_st = M_LO;
                M_LA: begin
                    if (rlow) m_st = M_LO;
                    else if (uv) m_ls = 1;
                    else if (von) m_ls = 0;
                end
                default: m_st = M_LO;
            endcase
        end
    end

    task automatic cmp(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    // compare all outputs against the model on every falling edge
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            int e_ramp;
            e_ramp = (m_st == M_SS) ? (m_ss / STEP) : (m_st == M_NM) ? CMAX : 0;
            cmp(cur_req, int'(startup_en), int'(m_st == M_LO || (m_st == M_LA && m_ls)), "startup_en");
            cmp(cur_req, int'(ref_en), int'(m_st == M_SS || m_st == M_NM || m_st == M_RS), "ref_en");
            cmp(cur_req, int'(gate_en), int'(m_st == M_SS || m_st == M_NM), "gate_en");
            cmp(cur_req, int'(ramp_code), e_ramp, "ramp_code");
            cmp(cur_req, int'(blank_src_en), int'(m_st == M_NM && m_bc == BLANKN), "blank_src_en");
        end
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic wait_cyc(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic turn_on();
        von = 1; wait_cyc(1); von = 0;
        wait_cyc(SS_TOTAL + 5);
    endtask

    task automatic clear_latch();
        rlow = 1; wait_cyc(1); rlow = 0; wait_cyc(2);
    endtask

    initial begin
        wait_cyc(3);
        #1;
        cmp("R1", int'(startup_en), 1, "reset startup_en");
        cmp("R1", int'(gate_en), 0, "reset gate_en");
        cmp("R1", int'(ramp_code), 0, "reset ramp_code");
        rst_n = 1;
        wait_cyc(2);
        cur_req = "R1";
        otp = 1; csh = 1; blo = 1; fbo = 1; ovp = 1;
        wait_cyc(4);
        otp = 0; csh = 0; blo = 0; fbo = 0; ovp = 0;
        wait_cyc(2);
        cur_req = "R2";
        von = 1; wait_cyc(1); von = 0;
        wait_cyc(1);
        cmp("R2", int'(gate_en), 1, "gate after turn-on");
        cmp("R2", int'(startup_en), 0, "startup after turn-on");
        cur_req = "R3";
        wait_cyc(STEP * 3);
        cmp("R3", int'(ramp_code), 3, "ramp mid soft start");
        wait_cyc(SS_TOTAL);
        cmp("R3", int'(ramp_code), CMAX, "ramp in normal");
        cur_req = "R8";
        fbo = 1; wait_cyc(BLANKN - 20); fbo = 0; wait_cyc(1);
        fbo = 1; wait_cyc(BLANKN - 5);
        cmp("R8", int'(blank_src_en), 0, "blank after interrupted overload");
        cur_req = "R9";
        bhi = 1; wait_cyc(5); bhi = 0;
        cmp("R9", int'(gate_en), 1, "pin high before extension");
        cur_req = "R7";
        wait_cyc(20);
        cmp("R7", int'(blank_src_en), 1, "blank source after window");
        cmp("R7", int'(gate_en), 1, "gate during extension");
        cur_req = "R8";
        fbo = 0; wait_cyc(1);
        cmp("R8", int'(blank_src_en), 0, "blank after drop");
        cur_req = "R9";
        fbo = 1; wait_cyc(BLANKN + 3);
        bhi = 1; wait_cyc(1); bhi = 0; fbo = 0;
        cmp("R9", int'(gate_en), 0, "gate in restart");
        cmp("R9", int'(ref_en), 1, "ref in restart");
        wait_cyc(10);
        uv = 1; wait_cyc(1); uv = 0;
        cmp("R9", int'(startup_en), 1, "lockout after restart");
        turn_on();
        cmp("R9", int'(ramp_code), CMAX, "normal after restart");
        cur_req = "R4";
        uv = 1; wait_cyc(1); uv = 0;
        cmp("R4", int'(startup_en), 1, "uv in normal");
        von = 1; wait_cyc(1); von = 0; wait_cyc(20);
        uv = 1; wait_cyc(1); uv = 0;
        cmp("R4", int'(gate_en), 0, "uv in soft start");
        cur_req = "R5";
        turn_on();
        ovp = 1; wait_cyc(5);
        cmp("R5", int'(gate_en), 1, "overvoltage alone");
        fbo = 1; wait_cyc(1); ovp = 0; fbo = 0;
        cmp("R5", int'(ref_en), 0, "ovp with overload");
        clear_latch();
        turn_on();
        csh = 1; wait_cyc(1); csh = 0;
        cmp("R5", int'(gate_en), 0, "short winding");
        clear_latch();
        von = 1; wait_cyc(1); von = 0; wait_cyc(30);
        blo = 1; wait_cyc(1); blo = 0;
        cmp("R5", int'(gate_en), 0, "blank pin low in soft start");
        clear_latch();
        cur_req = "R6";
        turn_on();
        uv = 1; otp = 1; wait_cyc(1); uv = 0; otp = 0;
        cmp("R6", int'(startup_en), 0, "latch beats uv");
        cur_req = "R10";
        uv = 1; wait_cyc(1); uv = 0; wait_cyc(3);
        cmp("R10", int'(startup_en), 1, "latched source on");
        von = 1; wait_cyc(1); von = 0; wait_cyc(3);
        cmp("R10", int'(startup_en), 0, "latched source off");
        cur_req = "R11";
        von = 1; otp = 1; fbo = 1; wait_cyc(10); von = 0; otp = 0; fbo = 0;
        cmp("R11", int'(gate_en), 0, "latched ignores turn-on");
        clear_latch();
        cmp("R11", int'(startup_en), 1, "lockout after clear");
        cur_req = "R6";
        turn_on();
        fbo = 1; wait_cyc(BLANKN + 2);
        uv = 1; bhi = 1; wait_cyc(1); uv = 0; bhi = 0; fbo = 0;
        cmp("R6", int'(startup_en), 1, "uv beats overload trip");
        wait_cyc(5);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule